// File: doc/BRIEF.md
# EEPROM Page Write Sequencer

This block sits between the serial bus engine of an EEPROM and its cell array. During a write transaction the bus engine hands it one strobe per received data byte. The first strobe after an idle period carries the target address. The sequencer keeps the page number from that address and places the byte at the matching offset of a page buffer. Each later byte goes to the next offset. Only the low offset bits advance, so a transaction that runs past the end of the page wraps to the start of the same page and overwrites the bytes loaded there earlier. A valid mask records which buffer locations hold data.

A stop strobe ends the transaction. If at least one byte was loaded and the protect input is low, the sequencer raises `busy_o`. It then walks the buffer from offset 0 upward and issues one array write for each loaded location. After that it holds busy for a fixed number of clocks, which covers the erase-then-program time of the cells. The bus engine uses `busy_o` to withhold acknowledges. If protect is high at the stop, or nothing was loaded, the buffer is discarded and no cycle runs. Byte and stop strobes that arrive while busy are ignored.

Top module: `page_write_seq`

## Requirements
- R1: After reset, `busy_o` and `mem_we_o` are low.
- R2: The first byte of a transaction lands at array address `byte_addr_i`. Each later byte of the same transaction lands at the next offset within the same page. A page is PAGE_BYTES (32) bytes, the offset is address bits [4:0], and the page is bits [ADDR_W-1:5] of the first byte's address.
- R3: When a transaction loads more than PAGE_BYTES bytes, the offset wraps from 31 to 0 and a later byte replaces the earlier byte at the same offset. Only the last value at each offset is written to the array.
- R4: Exactly one array write is issued for each distinct offset that was loaded. Offsets that were not loaded receive no write.
- R5: A stop with no byte loaded since the previous stop starts no cycle, and `busy_o` stays low.
- R6: If `wp_i` is high in the cycle the stop is taken, no array write is issued, `busy_o` stays low, and the loaded bytes are discarded.
- R7: A committing stop raises `busy_o` in the next cycle and holds it for exactly PAGE_BYTES + CYCLE_CLKS cycles. The array writes fall in the first PAGE_BYTES of those cycles, in ascending offset order.
- R8: Byte strobes and stops received while `busy_o` is high have no effect. They add no buffered byte and cause no write, and a later data-less stop still starts no cycle.
- R9: `mem_we_o` is never high while `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_wr_i | input | 1 | One-cycle strobe: a data byte was received |
| byte_addr_i | input | ADDR_W | Target address; used only with the first byte of a transaction |
| byte_data_i | input | DATA_W | Received data byte |
| stop_i | input | 1 | One-cycle strobe: a stop condition ended the transaction |
| wp_i | input | 1 | Whole-array write protect, active high |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_data_o | output | DATA_W | Array write data |
| busy_o | output | 1 | Write cycle in progress; the bus engine withholds acknowledges |

## Verification
The transaction patterns are a short run from a page start, a run starting mid-page, and a run that crosses the page end. These three separate correct offset counting from a pointer that carries into the page bits. A full page and a 35-byte run separate plain filling from overwrite on wrap, because the last value must win at offsets 3 to 5. A protected transaction, a data-less stop, and strobes injected during busy each show a write cycle that must not happen. The length of `busy_o` is measured in every case, which separates a committed cycle from a suppressed one.

// File: rtl/psq_pkg.sv
package psq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COMMIT = 2'd1,
        ST_HOLD   = 2'd2
    } psq_state_e;

endpackage

// File: rtl/psq_page_buf.sv
module psq_page_buf #(
    parameter int PAGE_BYTES = 32,
    parameter int DATA_W     = 8,
    localparam int OW        = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OW-1:0]     wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr,
    input  logic [OW-1:0]     rd_off,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              any_valid
);

    typedef struct packed {
        logic [PAGE_BYTES-1:0][DATA_W-1:0] data;
        logic [PAGE_BYTES-1:0]             vld;
    } buf_t;

    buf_t buf_d, buf_q;

    always_comb begin
        buf_d = buf_q;
        if (clr) begin
            buf_d.vld = '0;
        end
        if (wr_en) begin
            buf_d.data[wr_off] = wr_data;
            buf_d.vld[wr_off]  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else begin
            buf_q <= buf_d;
        end
    end

    assign rd_data   = buf_q.data[rd_off];
    assign rd_valid  = buf_q.vld[rd_off];
    assign any_valid = |buf_q.vld;

    // a cleared buffer holds no valid entry on the next cycle unless refilled
    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !wr_en) |=> !any_valid);  // R6

endmodule

// File: rtl/psq_cycle_timer.sv
module psq_cycle_timer #(
    parameter int CYCLE_CLKS = 150000,
    localparam int CW        = $clog2(CYCLE_CLKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic at_end;

    assign at_end = tmr_q.run && (tmr_q.cnt == CW'(CYCLE_CLKS - 1));

    always_comb begin
        tmr_d = tmr_q;
        if (start) begin
            tmr_d.run = 1'b1;
            tmr_d.cnt = '0;
        end else if (at_end) begin
            tmr_d.run = 1'b0;
            tmr_d.cnt = '0;
        end else if (tmr_q.run) begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign done = at_end;

    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.cnt < CW'(CYCLE_CLKS));  // R7

    AST_TIMER_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !tmr_q.run);  // R7

endmodule

// File: rtl/page_write_seq.sv
module page_write_seq
    import psq_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 32,
    parameter int CYCLE_CLKS = 150000,
    localparam int OW        = $clog2(PAGE_BYTES),
    localparam int PW        = ADDR_W - OW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_wr_i,
    input  logic [ADDR_W-1:0] byte_addr_i,
    input  logic [DATA_W-1:0] byte_data_i,
    input  logic              stop_i,
    input  logic              wp_i,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_data_o,
    output logic              busy_o
);

    typedef struct packed {
        psq_state_e    st;
        logic [PW-1:0] page;
        logic [OW-1:0] ptr;
        logic          loading;
        logic [OW-1:0] idx;
    } seq_t;

    seq_t s_d, s_q;

    logic              buf_wr, buf_clr, tmr_start, tmr_done;
    logic [OW-1:0]     buf_off;
    logic [DATA_W-1:0] rd_data;
    logic              rd_valid, any_valid;

    always_comb begin
        s_d       = s_q;
        buf_wr    = 1'b0;
        buf_clr   = 1'b0;
        buf_off   = s_q.loading ? s_q.ptr : byte_addr_i[OW-1:0];
        tmr_start = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (stop_i) begin
                    s_d.loading = 1'b0;
                    if (any_valid && !wp_i) begin
                        s_d.st  = ST_COMMIT;
                        s_d.idx = '0;
                    end else begin
                        buf_clr = 1'b1;
                    end
                end else if (byte_wr_i) begin
                    buf_wr      = 1'b1;
                    s_d.loading = 1'b1;
                    s_d.ptr     = buf_off + 1'b1;
                    if (!s_q.loading) begin
                        s_d.page = byte_addr_i[ADDR_W-1:OW];
                    end
                end
            end
            ST_COMMIT: begin
                s_d.idx = s_q.idx + 1'b1;
                if (s_q.idx == OW'(PAGE_BYTES - 1)) begin
                    s_d.st    = ST_HOLD;
                    buf_clr   = 1'b1;
                    tmr_start = 1'b1;
                end
            end
            ST_HOLD: begin
                if (tmr_done) begin
                    s_d.st = ST_IDLE;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    psq_page_buf #(
        .PAGE_BYTES (PAGE_BYTES),
        .DATA_W     (DATA_W)
    ) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (buf_wr),
        .wr_off    (buf_off),
        .wr_data   (byte_data_i),
        .clr       (buf_clr),
        .rd_off    (s_q.idx),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .any_valid (any_valid)
    );

    psq_cycle_timer #(
        .CYCLE_CLKS (CYCLE_CLKS)
    ) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .done  (tmr_done)
    );

    assign busy_o     = (s_q.st != ST_IDLE);
    assign mem_we_o   = (s_q.st == ST_COMMIT) && rd_valid;
    assign mem_addr_o = {s_q.page, s_q.idx};
    assign mem_data_o = rd_data;

    AST_WE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> busy_o);  // R9

    AST_PROTECT_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && stop_i && wp_i) |=> !busy_o);  // R6

    AST_EMPTY_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && stop_i && !any_valid) |=> !busy_o);  // R5

    AST_COMMIT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && stop_i && !wp_i && any_valid) |=> busy_o);  // R7

    AST_ASCEND_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_COMMIT && s_q.idx != '0) |->
            ($past(s_q.st) == ST_COMMIT && $past(s_q.idx) + 1'b1 == s_q.idx));  // R7

    AST_BUSY_PAGE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(s_q.page));  // R8

endmodule

// File: tb/tb_page_write_seq.sv
module tb_page_write_seq;

    localparam int AW  = 8;
    localparam int DW  = 8;
    localparam int PB  = 32;
    localparam int CYC = 20;
    localparam int NV  = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          byte_wr_i = 1'b0;
    logic [AW-1:0] byte_addr_i = '0;
    logic [DW-1:0] byte_data_i = '0;
    logic          stop_i = 1'b0;
    logic          wp_i = 1'b0;
    logic          mem_we_o, busy_o;
    logic [AW-1:0] mem_addr_o;
    logic [DW-1:0] mem_data_o;

    always #10 clk = ~clk;

    page_write_seq #(
        .ADDR_W (AW), .DATA_W (DW), .PAGE_BYTES (PB), .CYCLE_CLKS (CYC)
    ) dut (
        .clk (clk), .rst_n (rst_n), .byte_wr_i (byte_wr_i),
        .byte_addr_i (byte_addr_i), .byte_data_i (byte_data_i),
        .stop_i (stop_i), .wp_i (wp_i), .mem_we_o (mem_we_o),
        .mem_addr_o (mem_addr_o), .mem_data_o (mem_data_o), .busy_o (busy_o)
    );

    // {wp, start address, byte count, data seed}
    localparam logic [24:0] VEC [NV] = '{
        {1'b0, 8'h00, 8'd4,  8'h10},
        {1'b0, 8'h45, 8'd3,  8'h20},
        {1'b0, 8'h7E, 8'd5,  8'h30},
        {1'b0, 8'h80, 8'd32, 8'h40},
        {1'b0, 8'hA3, 8'd35, 8'h70},
        {1'b1, 8'h10, 8'd6,  8'h99},
        {1'b0, 8'h00, 8'd0,  8'h00},
        {1'b0, 8'hE0, 8'd1,  8'hFF}
    };

    int n_chk = 0, n_bad = 0;
    bit finished = 0;
    logic [DW-1:0] arr [1 << AW];
    logic [DW-1:0] exp_arr [1 << AW];
    int wr_cnt = 0, idle_we = 0, order_bad = 0;
    int last_off = -1;

    task automatic check(input string req, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // array-side monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (mem_we_o) begin
            arr[mem_addr_o] = mem_data_o;
            wr_cnt++;
            if (int'(mem_addr_o[4:0]) <= last_off) order_bad++;
            last_off = int'(mem_addr_o[4:0]);
            if (!busy_o) idle_we++;
        end
    end

    task automatic pulse_byte(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(posedge clk); #1;
        byte_wr_i = 1'b1; byte_addr_i = a; byte_data_i = d;
        @(posedge clk); #1;
        byte_wr_i = 1'b0;
    endtask

    task automatic pulse_stop(input logic wp);
        @(posedge clk); #1;
        stop_i = 1'b1; wp_i = wp;
        @(posedge clk); #1;
        stop_i = 1'b0; wp_i = 1'b0;
    endtask

    // counts busy cycles following the stop just taken
    task automatic busy_len(output int n, input bit inject);
        n = 0;
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            if (!busy_o) break;
            n++;
            if (inject && n == 5) begin
                byte_wr_i = 1'b1; byte_addr_i = 8'h33; byte_data_i = 8'h5A;
                stop_i = 1'b1;
                @(negedge clk);
                n += busy_o ? 1 : 0;
                byte_wr_i = 1'b0; stop_i = 1'b0;
            end
        end
    endtask

    function automatic int arr_diff();
        int d = 0;
        for (int i = 0; i < (1 << AW); i++)
            if (arr[i] !== exp_arr[i]) d++;
        return d;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int blen;
        for (int i = 0; i < (1 << AW); i++) begin
            arr[i] = 8'h00;
            exp_arr[i] = 8'h00;
        end
        repeat (3) @(posedge clk);
        #1;
        check("R1 busy at reset", int'(busy_o), 0);
        check("R1 we at reset", int'(mem_we_o), 0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        for (int v = 0; v < NV; v++) begin
            logic          wp;
            logic [AW-1:0] sa;
            int            nb;
            logic [DW-1:0] sd;
            int            exp_w, exp_b;
            bit            hit [PB];
            {wp, sa, nb, sd} = {VEC[v][24], VEC[v][23:16], int'(VEC[v][15:8]), VEC[v][7:0]};
            for (int k = 0; k < PB; k++) hit[k] = 0;
            exp_w = 0;
            wr_cnt = 0; last_off = -1; order_bad = 0;
            for (int k = 0; k < nb; k++) begin
                logic [AW-1:0] a;
                a = {sa[AW-1:5], 5'(sa[4:0] + 5'(k))};
                pulse_byte(sa + AW'(k), sd + DW'(k));
                if (!wp) begin
                    exp_arr[a] = sd + DW'(k);
                    if (!hit[a[4:0]]) exp_w++;
                    hit[a[4:0]] = 1;
                end
            end
            pulse_stop(wp);
            busy_len(blen, 1'b0);
            exp_b = (exp_w > 0) ? PB + CYC : 0;
            check($sformatf("R2 R3 R6 array contents v%0d", v), arr_diff(), 0);
            check($sformatf("R4 write count v%0d", v), wr_cnt, exp_w);
            check($sformatf("R7 R5 busy length v%0d", v), blen, exp_b);
            check($sformatf("R7 ascending order v%0d", v), order_bad, 0);
        end

        // R8: strobes during busy are dropped
        wr_cnt = 0; last_off = -1; order_bad = 0;
        pulse_byte(8'h44, 8'hC3);
        exp_arr[8'h44] = 8'hC3;
        pulse_stop(1'b0);
        busy_len(blen, 1'b1);
        check("R8 busy length with injected strobes", blen, PB + CYC);
        check("R8 single write only", wr_cnt, 1);
        check("R8 array unchanged by dropped byte", arr_diff(), 0);
        wr_cnt = 0;
        pulse_stop(1'b0);
        busy_len(blen, 1'b0);
        check("R8 later empty stop starts no cycle", blen, 0);
        check("R8 no write after dropped byte", wr_cnt, 0);
        check("R9 no write strobe while idle", idle_we, 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule